// File: doc/BRIEF.md
# Debug Address Match Unit

The block gives a processor core four hardware breakpoint and watchpoint slots. Each slot holds an address. A single packed control word gives each slot its access type, its length and a pair of enables. The unit watches a stream of bus events: instruction fetches, data reads, data writes and I/O accesses. Each event carries an address and a byte size. When an enabled slot covers an event's bytes and accepts its access kind, the unit sets that slot's sticky hit bit in a status register. In the next cycle it raises a one-cycle trap pulse.

Software reaches the unit through a small indexed register port. Indices 0 to 3 are the slot addresses, index 6 is status and index 7 is control. Writes take effect at the clock edge, and reads are combinational. A task-switch pulse from the core drops the per-task (local) enables and keeps the global ones. This lets debug state that belongs to one task disappear on a context change.

Top module: `dbg_match_unit`

## Requirements
- R1: After a synchronous active-low reset, every register (slot addresses, status and control) reads as zero and `trap` is low.
- R2: Register index 0..3 reads and writes slot address 0..3. Index 6 is status, with hit bits in [3:0] and zero above. Index 7 is control. Indices 4 and 5 read as zero and ignore writes.
- R3: Control bits 10 to 15 ignore writes and always read as zero. Bits 0..9 and 16..31 read back as written. Bits 8 and 9 are the local and global exact-match flags.
- R4: Slot i has a local enable at control bit 2*i and a global enable at bit 2*i+1. A slot with both enables clear never matches.
- R5: Slot i takes a 4-bit field at control bit 16+4*i. The low 2 bits are the access type and the upper 2 bits are the length code: 00 = 1 byte, 01 = 2, 11 = 4, 10 = 8. The covered range starts at the slot address with its low log2(length) bits cleared and spans that length.
- R6: The event kind is encoded as 0 = fetch, 1 = data read, 2 = data write and 3 = I/O. Access type 00 matches only fetches and always covers 1 byte. Type 01 matches writes. Type 11 matches reads and writes. Type 10 matches I/O.
- R7: An event covers bytes addr .. addr + 2^size - 1, where `ev_size` is 0..3. A slot matches when that range overlaps the slot's range in at least one byte.
- R8: A match sets status bit i, and the bit stays set until software writes a zero to it. A match in the same cycle as a status write wins for that bit.
- R9: `trap` is high for exactly the cycle after an event that matched at least one slot, and low after any cycle with no match.
- R10: A `task_switch` pulse clears all local enable bits and leaves global enables and other bits unchanged. If it coincides with a control write, the written value is stored with its local enables cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_idx`) |
| task_switch | input | 1 | One-cycle task-switch pulse |
| ev_valid | input | 1 | Bus event valid |
| ev_kind | input | 2 | Event kind: 0 fetch, 1 read, 2 write, 3 I/O |
| ev_addr | input | ADDR_W | Event start address |
| ev_size | input | 2 | log2 of event byte count |
| trap | output | 1 | One-cycle debug trap pulse |

## Verification
The assertions check on every cycle several rules that hold regardless of configuration. The reserved control bits always read as zero. Local enables are gone after a task switch, and global enables survive it. Hit bits never drop without a status write. A slot whose enables were both clear never raises its hit bit. The trap follows only cycles that carried an event. Only the bench scenarios can show the decoding itself: the length codes, the address alignment of the slot range, the pairing of access type with event kind, and byte-range overlap at range edges. The same holds for precedence when a hit and a clearing write coincide.

// File: rtl/dbg_match_pkg.sv
// Package: shared encodings and helpers for the debug address match unit.
// Assumes a 32-bit register port and exactly four slots in the control layout.
package dbg_match_pkg;

    localparam int DATA_W      = 32;
    localparam int NUM_SLOTS   = 4;
    localparam int FIELD_BASE  = 16;
    localparam int FIELD_W     = 4;
    localparam int SLOW_LOCAL  = 8;
    localparam int SLOW_GLOBAL = 9;
    localparam int RSV_LO      = 10;
    localparam int RSV_HI      = 15;

    localparam logic [2:0] IDX_STATUS = 3'd6;
    localparam logic [2:0] IDX_CTRL   = 3'd7;

    typedef enum logic [1:0] {
        EV_FETCH = 2'd0,
        EV_READ  = 2'd1,
        EV_WRITE = 2'd2,
        EV_IO    = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        ACC_EXEC  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_IO    = 2'b10,
        ACC_RDWR  = 2'b11
    } acc_type_e;

    // Length code to log2 of byte count.
    function automatic logic [1:0] len_log2(input logic [1:0] code);
        case (code)
            2'b00:   len_log2 = 2'd0;
            2'b01:   len_log2 = 2'd1;
            2'b11:   len_log2 = 2'd2;
            default: len_log2 = 2'd3;
        endcase
    endfunction

    // Bits of the control word that hold storage (reserved bits excluded).
    function automatic logic [DATA_W-1:0] ctrl_keep_mask();
        logic [DATA_W-1:0] m;
        m = '1;
        for (int b = RSV_LO; b <= RSV_HI; b++) m[b] = 1'b0;
        return m;
    endfunction

    // Bits of the control word that hold local enables.
    function automatic logic [DATA_W-1:0] local_en_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SLOTS; s++) m[2*s] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dbg_slot_match.sv
// Module: dbg_slot_match
// Combinational compare of one slot against the current bus event.
// Assumes the slot range is aligned to its length; execute slots cover 1 byte.
module dbg_slot_match
    import dbg_match_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic              en_local,
    input  logic              en_global,
    input  logic [3:0]        field,
    input  logic              ev_valid,
    input  logic [1:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [1:0]        ev_size,
    output logic              hit
);

    localparam int EXT_W = ADDR_W + 1;

    logic [1:0]       acc;
    logic [1:0]       slot_lg;
    logic             kind_ok;
    logic [EXT_W-1:0] s_lo, s_hi, e_lo, e_hi;
    logic [EXT_W-1:0] s_span, e_span;

    // Decode access type and effective length of the slot.
    always_comb begin
        acc     = field[1:0];
        slot_lg = (acc == ACC_EXEC) ? 2'd0 : len_log2(field[3:2]);
    end

    // Pair the slot access type with the event kind.
    always_comb begin
        case (acc)
            ACC_EXEC:  kind_ok = (ev_kind == EV_FETCH);
            ACC_WRITE: kind_ok = (ev_kind == EV_WRITE);
            ACC_RDWR:  kind_ok = (ev_kind == EV_READ) || (ev_kind == EV_WRITE);
            default:   kind_ok = (ev_kind == EV_IO);
        endcase
    end

    // Form both byte ranges one bit wider so the end never wraps.
    always_comb begin
        s_span = (EXT_W'(1) << slot_lg) - EXT_W'(1);
        e_span = (EXT_W'(1) << ev_size) - EXT_W'(1);
        s_lo   = {1'b0, slot_addr & ({ADDR_W{1'b1}} << slot_lg)};
        s_hi   = s_lo + s_span;
        e_lo   = {1'b0, ev_addr};
        e_hi   = e_lo + e_span;
    end

    // Overlap test gated by enables and kind.
    always_comb begin
        hit = ev_valid && (en_local || en_global) && kind_ok &&
              (e_lo <= s_hi) && (s_lo <= e_hi);
    end

endmodule

// File: rtl/dbg_ctrl_reg.sv
// Module: dbg_ctrl_reg
// Holds the packed control word; masks reserved bits and applies task switches.
// Assumes a task switch is applied after any same-cycle software write.
module dbg_ctrl_reg
    import dbg_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              task_switch,
    output logic [DATA_W-1:0] ctrl_q
);

    localparam logic [DATA_W-1:0] KEEP  = ctrl_keep_mask();
    localparam logic [DATA_W-1:0] LOCAL = local_en_mask();

    logic [DATA_W-1:0] written;

    // Pick the software value or the held value.
    always_comb begin
        written = wr_en ? (wdata & KEEP) : ctrl_q;
    end

    // Register the control word, dropping local enables on a task switch.
    always_ff @(posedge clk) begin
        if (!rst_n)           ctrl_q <= '0;
        else if (task_switch) ctrl_q <= written & ~LOCAL;
        else                  ctrl_q <= written;
    end

endmodule

// File: rtl/dbg_status_reg.sv
// Module: dbg_status_reg
// Sticky per-slot hit bits and the registered trap pulse.
// Assumes hits from the current cycle override a same-cycle clearing write.
module dbg_status_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] hit,
    output logic [N-1:0] status_q,
    output logic         trap_q
);

    // Update the hit bits: software value or held value, OR new hits.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (wr_en ? wdata : status_q) | hit;
    end

    // One-cycle trap after any matching event.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= |hit;
    end

endmodule

// File: rtl/dbg_match_unit.sv
// Module: dbg_match_unit (top)
// Four address slots, packed control word, sticky status and trap output,
// reached through an indexed register port with combinational reads.
// Assumes ADDR_W <= 32 so slot addresses fit the register port.
module dbg_match_unit
    import dbg_match_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              task_switch,
    input  logic              ev_valid,
    input  logic [1:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [1:0]        ev_size,
    output logic              trap
);

    logic [ADDR_W-1:0]    slot_addr_q [NUM_SLOTS];
    logic [DATA_W-1:0]    ctrl_q;
    logic [NUM_SLOTS-1:0] status_q;
    logic [NUM_SLOTS-1:0] hit;
    logic                 wr_ctrl, wr_status;

    // Decode writes to the control and status registers.
    always_comb begin
        wr_ctrl   = reg_wr && (reg_idx == IDX_CTRL);
        wr_status = reg_wr && (reg_idx == IDX_STATUS);
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        // Slot address register.
        always_ff @(posedge clk) begin
            if (!rst_n)                              slot_addr_q[i] <= '0;
            else if (reg_wr && (reg_idx == 3'(i)))   slot_addr_q[i] <= reg_wdata[ADDR_W-1:0];
        end

        dbg_slot_match #(.ADDR_W(ADDR_W)) u_match (
            .slot_addr (slot_addr_q[i]),
            .en_local  (ctrl_q[2*i]),
            .en_global (ctrl_q[2*i+1]),
            .field     (ctrl_q[FIELD_BASE + FIELD_W*i +: FIELD_W]),
            .ev_valid  (ev_valid),
            .ev_kind   (ev_kind),
            .ev_addr   (ev_addr),
            .ev_size   (ev_size),
            .hit       (hit[i])
        );
    end

    dbg_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_ctrl),
        .wdata       (reg_wdata),
        .task_switch (task_switch),
        .ctrl_q      (ctrl_q)
    );

    dbg_status_reg #(.N(NUM_SLOTS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_status),
        .wdata    (reg_wdata[NUM_SLOTS-1:0]),
        .hit      (hit),
        .status_q (status_q),
        .trap_q   (trap)
    );

    // Combinational read multiplexer over the register map.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (reg_idx == 3'(i)) reg_rdata = DATA_W'(slot_addr_q[i]);
        end
        if (reg_idx == IDX_STATUS) reg_rdata = DATA_W'(status_q);
        if (reg_idx == IDX_CTRL)   reg_rdata = ctrl_q;
    end

endmodule

// File: rtl/dbg_match_chk.sv
// Module: dbg_match_chk
// Cycle-by-cycle property checks for dbg_match_unit, attached by bind.
module dbg_match_chk
    import dbg_match_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [2:0]           reg_idx,
    input logic [31:0]          reg_rdata,
    input logic                 task_switch,
    input logic                 ev_valid,
    input logic                 trap,
    input logic [DATA_W-1:0]    ctrl_q,
    input logic [NUM_SLOTS-1:0] status_q
);

    localparam logic [DATA_W-1:0] LOCAL  = local_en_mask();
    localparam logic [DATA_W-1:0] GLOBAL = LOCAL << 1;

    // R3
    rsv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_CTRL) |-> (reg_rdata[15:10] == 6'd0));

    // R10
    local_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch |=> ((ctrl_q & LOCAL) == '0));

    // R10
    global_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (task_switch && !(reg_wr && reg_idx == IDX_CTRL))
        |=> ((ctrl_q & GLOBAL) == ($past(ctrl_q) & GLOBAL)));

    // R8
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_idx == IDX_STATUS)
        |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R9
    trap_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> !trap);

    // R9
    trap_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (status_q != '0));

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_en
        // R4
        disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(status_q[i]) && !$past(reg_wr && reg_idx == IDX_STATUS))
            |-> ($past(ctrl_q[2*i +: 2]) != 2'b00));
    end

endmodule

bind dbg_match_unit dbg_match_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_idx     (reg_idx),
    .reg_rdata   (reg_rdata),
    .task_switch (task_switch),
    .ev_valid    (ev_valid),
    .trap        (trap),
    .ctrl_q      (ctrl_q),
    .status_q    (status_q)
);

// File: tb/tb_dbg_match_unit.sv
`timescale 1ns/1ps
module tb_dbg_match_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        task_switch = 1'b0;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_kind = 2'd0;
    logic [31:0] ev_addr = '0;
    logic [1:0]  ev_size = 2'd0;
    logic        trap;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_match_unit dut (.*);

    typedef struct packed {
        logic [1:0]  slot;
        logic [31:0] addr;
        logic [1:0]  rw;
        logic [1:0]  len;
        logic [1:0]  en;
        logic [1:0]  kind;
        logic [31:0] eaddr;
        logic [1:0]  esize;
        logic        exp;
    } vec_t;

    // kind: 0 fetch, 1 read, 2 write, 3 io
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h1000, 2'b01, 2'b11, 2'b01, 2'd2, 32'h1002, 2'd0, 1'b1}, // R5 R6 write in 4B
        '{2'd0, 32'h1000, 2'b01, 2'b11, 2'b01, 2'd1, 32'h1002, 2'd0, 1'b0}, // R6 read vs write-only
        '{2'd1, 32'h2000, 2'b11, 2'b00, 2'b10, 2'd1, 32'h2000, 2'd0, 1'b1}, // R4 global enable
        '{2'd1, 32'h2000, 2'b11, 2'b00, 2'b00, 2'd1, 32'h2000, 2'd0, 1'b0}, // R4 both clear
        '{2'd2, 32'h3006, 2'b01, 2'b11, 2'b01, 2'd2, 32'h3004, 2'd0, 1'b1}, // R5 aligned base
        '{2'd2, 32'h3006, 2'b01, 2'b11, 2'b01, 2'd2, 32'h3008, 2'd0, 1'b0}, // R5 past end
        '{2'd3, 32'h4000, 2'b00, 2'b11, 2'b01, 2'd0, 32'h4000, 2'd0, 1'b1}, // R6 exec hit
        '{2'd3, 32'h4000, 2'b00, 2'b11, 2'b01, 2'd0, 32'h4001, 2'd0, 1'b0}, // R6 exec 1 byte
        '{2'd3, 32'h4000, 2'b00, 2'b00, 2'b01, 2'd1, 32'h4000, 2'd0, 1'b0}, // R6 exec vs read
        '{2'd0, 32'h5000, 2'b10, 2'b00, 2'b01, 2'd3, 32'h5000, 2'd0, 1'b1}, // R6 io
        '{2'd0, 32'h5000, 2'b10, 2'b00, 2'b01, 2'd2, 32'h5000, 2'd0, 1'b0}, // R6 io vs write
        '{2'd1, 32'h6008, 2'b01, 2'b10, 2'b10, 2'd2, 32'h600F, 2'd0, 1'b1}, // R5 8B last byte
        '{2'd1, 32'h6008, 2'b01, 2'b10, 2'b10, 2'd2, 32'h6010, 2'd0, 1'b0}, // R5 8B beyond
        '{2'd0, 32'h7004, 2'b11, 2'b00, 2'b01, 2'd1, 32'h7002, 2'd2, 1'b1}, // R7 overlap
        '{2'd0, 32'h7004, 2'b11, 2'b00, 2'b01, 2'd1, 32'h7000, 2'd2, 1'b0}, // R7 adjacent
        '{2'd2, 32'h8001, 2'b11, 2'b01, 2'b11, 2'd2, 32'h7FFF, 2'd1, 1'b1}, // R7 R5 2B straddle
        '{2'd3, 32'h9000, 2'b11, 2'b11, 2'b01, 2'd1, 32'h8FF8, 2'd3, 1'b0}, // R7 8B ends below
        '{2'd3, 32'h9000, 2'b11, 2'b11, 2'b01, 2'd2, 32'h8FFC, 2'd3, 1'b1}  // R7 8B reaches
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        reg_idx = idx;
        #1;
        v = reg_rdata;
    endtask

    // Apply one event; after the capture edge return trap and status.
    task automatic fire(input logic [1:0] k, input logic [31:0] a, input logic [1:0] sz,
                        output logic t, output logic [31:0] st, output logic t_after);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = k; ev_addr = a; ev_size = sz;
        @(negedge clk);
        ev_valid = 1'b0;
        #1;
        t = trap;
        rd(3'd6, st);
        @(negedge clk);
        #1;
        t_after = trap;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, st;
        logic t, ta;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            check("R1 reset reg", v, 32'h0);
        end
        check("R1 reset trap", {31'b0, trap}, 32'h0);

        // R2: slot address read back and unused indices
        for (int i = 0; i < 4; i++) wr(3'(i), 32'hA000_0000 + 32'(i) * 32'h111);
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), v);
            check("R2 slot readback", v, 32'hA000_0000 + 32'(i) * 32'h111);
        end
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd4, v); check("R2 idx4 zero", v, 32'h0);
        rd(3'd5, v); check("R2 idx5 zero", v, 32'h0);

        // R3: reserved bits
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd7, v); check("R3 reserved masked", v, 32'hFFFF_03FF);
        wr(3'd7, 32'h0000_0300);
        rd(3'd7, v); check("R3 exact-match flags", v, 32'h0000_0300);

        // R1: reset clears loaded state
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            check("R1 re-reset reg", v, 32'h0);
        end

        // Vector table: R4 R5 R6 R7 R9
        for (int n = 0; n < NV; n++) begin
            vec_t e;
            logic [31:0] cw;
            e = VECS[n];
            wr(3'd7, 32'h0);
            wr(3'd6, 32'h0);
            wr({1'b0, e.slot}, e.addr);
            cw = (32'(e.en) << (2 * e.slot)) | (32'({e.len, e.rw}) << (16 + 4 * e.slot));
            wr(3'd7, cw);
            fire(e.kind, e.eaddr, e.esize, t, st, ta);
            check($sformatf("R5/R6/R7 vec%0d status", n), st, 32'(e.exp) << e.slot);
            check($sformatf("R9 vec%0d trap", n), {31'b0, t}, {31'b0, e.exp});
            check($sformatf("R9 vec%0d trap one cycle", n), {31'b0, ta}, 32'h0);
        end

        // R8: sticky and clear
        wr(3'd7, 32'h0);
        wr(3'd6, 32'h0);
        wr(3'd0, 32'h1000);
        wr(3'd7, 32'h0001_0001);            // slot0 write, 1 byte, local
        fire(2'd2, 32'h1000, 2'd0, t, st, ta);
        check("R8 hit set", st, 32'h1);
        fire(2'd2, 32'h2000, 2'd0, t, st, ta);
        check("R8 sticky without hit", st, 32'h1);
        check("R9 no trap on miss", {31'b0, t}, 32'h0);
        wr(3'd6, 32'h0);
        rd(3'd6, v); check("R8 cleared by write", v, 32'h0);
        // R8: hit beats same-cycle clear
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = 2'd2; ev_addr = 32'h1000; ev_size = 2'd0;
        reg_wr = 1'b1; reg_idx = 3'd6; reg_wdata = 32'h0;
        @(negedge clk);
        ev_valid = 1'b0; reg_wr = 1'b0;
        rd(3'd6, v); check("R8 hit wins over clear", v, 32'h1);

        // R10: task switch
        wr(3'd6, 32'h0);
        wr(3'd7, 32'h0001_03FF);
        @(negedge clk); task_switch = 1'b1;
        @(negedge clk); task_switch = 1'b0;
        rd(3'd7, v); check("R10 locals cleared", v, 32'h0001_03AA);
        wr(3'd7, 32'h0001_0001);            // slot0 local only
        @(negedge clk); task_switch = 1'b1;
        @(negedge clk); task_switch = 1'b0;
        fire(2'd2, 32'h1000, 2'd0, t, st, ta);
        check("R10 local slot stops matching", st, 32'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 3'd7; reg_wdata = 32'h0000_0255; task_switch = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; task_switch = 1'b0;
        rd(3'd7, v); check("R10 write with task switch", v, 32'h0000_0200);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule